// File: doc/BRIEF.md
# Serial receive FIFO with trigger levels

This block is the buffering stage on the receive side of a byte-oriented serial channel. A deserialiser hands it one byte per write strobe. Software or a bus adapter reads bytes back through a pop strobe. The block holds up to sixteen bytes in arrival order and keeps a fill count.

From that count it derives three indications. The first is a trigger-reached flag, set once the fill reaches a selectable level. The second is a data-present flag, set while some bytes wait but the trigger level has not been reached. The third is a ready-to-accept output, which tells the far end to pause once the fill reaches a separately selected flow-control limit.

A byte that arrives while all sixteen slots are taken is discarded and raises a sticky overrun flag. A flush control empties the store.

Top module: `rxq_trig_top`

## Requirements
- R1: The store holds at most 16 bytes, and `count_o` always reports the number of bytes held.
- R2: A push that finds 16 bytes stored, with no pop in the same cycle, discards the byte and sets `overrun_o`. The flag stays set until a cycle with `ovr_clr_i` high and no new discard; a discard in that same cycle wins over the clear.
- R3: `trig_sel_i` selects the trigger level with this encoding: 0 gives 1 byte, 1 gives 4 bytes, 2 gives 8 bytes, 3 gives 14 bytes.
- R4: While the count is at or above the trigger level, `fsr_o` bit 1 (trigger reached) is 1 and bit 0 (data present) is 0.
- R5: While the count is below the trigger level, `fsr_o` bit 1 is 0, and bit 0 is 1 exactly when the count is non-zero.
- R6: `lim_sel_i` values 0 to 7 select the flow-control limit 15, 1, 4, 6, 8, 10, 12 or 14 bytes. `rx_ready_o` is 1 exactly while the count is below that limit. The limit does not stop pushes from being stored.
- R7: After reset, `fsr_o` reads 0x0060 (bits 6:5 are fixed at 1 and all other bits other than 1:0 are fixed at 0), the count is 0 and `overrun_o` is 0.
- R8: `rdata_o` shows the oldest stored byte, or 0 when the store is empty. `pop_i` removes that byte. A pop on an empty store has no effect.
- R9: A push and a pop in the same cycle on a non-empty store leave the count unchanged and keep arrival order. This also holds when the store is full.
- R10: While `flush_i` is high, the store is emptied at each clock, pushes are discarded without setting `overrun_o`, and `fsr_o` bits 1:0 read 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Byte write strobe from the deserialiser |
| push_data_i | input | 8 | Byte to store |
| pop_i | input | 1 | Read strobe that removes the oldest byte |
| rdata_o | output | 8 | Oldest stored byte, 0 when empty |
| flush_i | input | 1 | Empties the store while high |
| trig_sel_i | input | 2 | Trigger level select |
| lim_sel_i | input | 3 | Flow-control limit select |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| fsr_o | output | 16 | Status word: bit 0 data present, bit 1 trigger reached |
| overrun_o | output | 1 | Sticky overrun flag |
| rx_ready_o | output | 1 | Ready to accept more bytes |
| count_o | output | 5 | Fill count |

## Verification
A push, pop or flush acts at the clock edge where it is sampled. The count, `rdata_o`, both status flags and `rx_ready_o` follow from that new count through combinational logic, so they are all due one edge after the stimulus. `overrun_o` is a register and is due at that same edge.

Level-select changes have no register in their path. They affect the flags and ready output within the same cycle.

The bench drives every input just after a falling edge and lets one rising edge pass. It compares at the next falling edge against a byte-queue model that it updates in the same order as the requirements state.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned FSR_DP  = 0;
  localparam int unsigned FSR_TRG = 1;
  localparam logic [15:0] FSR_FIXED = 16'h0060;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int unsigned flow_limit(input logic [2:0] sel);
    if (sel == 3'd0) return 15;
    if (sel == 3'd1) return 1;
    return 2 * int'(sel);
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          drop_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic full, empty, do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop_i && !empty && !flush_i;
  assign do_push = push_i && !flush_i && (!full || do_pop);
  assign drop_o  = push_i && !flush_i && full && !do_pop;
  assign head_o  = empty ? '0 : mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  p_count_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  p_both_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !flush_i && count_o != '0) |=> $stable(count_o));
  p_flush_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_o == '0));
  p_pop_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0 && pop_i && !push_i) |=> (count_o == '0));
endmodule

// File: rtl/rxq_status.sv
module rxq_status #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic [1:0]    trig_sel_i,
  input  logic [2:0]    lim_sel_i,
  input  logic          drop_i,
  input  logic          ovr_clr_i,
  output logic [15:0]   fsr_o,
  output logic          ready_o,
  output logic          overrun_o
);
  import rxq_pkg::*;
  logic at_trig;
  logic ovr_q;

  assign at_trig = int'(count_i) >= int'(trig_level(trig_sel_i));
  assign ready_o = int'(count_i) <  int'(flow_limit(lim_sel_i));

  always_comb begin
    fsr_o          = FSR_FIXED;
    fsr_o[FSR_TRG] = at_trig;
    fsr_o[FSR_DP]  = !at_trig && (count_i != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_q <= 1'b0;
    else if (drop_i)    ovr_q <= 1'b1;
    else if (ovr_clr_i) ovr_q <= 1'b0;
  end
  assign overrun_o = ovr_q;

  p_overrun_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> overrun_o);
  p_flag_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fsr_o[FSR_TRG] && fsr_o[FSR_DP]));
  p_full_stops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == CW'(DEPTH)) |-> !ready_o);
  p_empty_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == '0) |-> (fsr_o[1:0] == 2'b00));
endmodule

// File: rtl/rxq_trig_top.sv
module rxq_trig_top #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  input  logic          flush_i,
  input  logic [1:0]    trig_sel_i,
  input  logic [2:0]    lim_sel_i,
  input  logic          ovr_clr_i,
  output logic [15:0]   fsr_o,
  output logic          overrun_o,
  output logic          rx_ready_o,
  output logic [CW-1:0] count_o
);
  logic [CW-1:0] cnt;
  logic          drop;

  rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .push_i  (push_i),
    .data_i  (push_data_i),
    .pop_i   (pop_i),
    .head_o  (rdata_o),
    .count_o (cnt),
    .drop_o  (drop)
  );

  rxq_status #(.DEPTH(DEPTH)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_i    (cnt),
    .trig_sel_i (trig_sel_i),
    .lim_sel_i  (lim_sel_i),
    .drop_i     (drop),
    .ovr_clr_i  (ovr_clr_i),
    .fsr_o      (fsr_o),
    .ready_o    (rx_ready_o),
    .overrun_o  (overrun_o)
  );

  assign count_o = cnt;

  p_flush_no_ovr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !overrun_o) |=> !overrun_o);
endmodule

// File: tb/rxq_trig_top_tb.sv
module rxq_trig_top_tb_top;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic push = 0, pop = 0, flush = 0, ovr_clr = 0;
  logic [7:0] din = 0;
  logic [1:0] tsel = 0;
  logic [2:0] lsel = 0;
  logic [7:0] rdata;
  logic [15:0] fsr;
  logic ovr, rdy;
  logic [4:0] cnt;
  int checks = 0, fails = 0;
  byte unsigned q[$];
  bit m_ovr = 0;

  always #(PERIOD/2) clk = ~clk;

  rxq_trig_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(din), .pop_i(pop),
    .rdata_o(rdata), .flush_i(flush), .trig_sel_i(tsel), .lim_sel_i(lsel),
    .ovr_clr_i(ovr_clr), .fsr_o(fsr), .overrun_o(ovr), .rx_ready_o(rdy),
    .count_o(cnt));

  function automatic int trig_of(input logic [1:0] s);
    int t[4] = '{1, 4, 8, 14};
    return t[s];
  endfunction
  function automatic int lim_of(input logic [2:0] s);
    int t[8] = '{15, 1, 4, 6, 8, 10, 12, 14};
    return t[s];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    int n = q.size();
    int e_fsr = 16'h0060;
    if (n >= trig_of(tsel)) e_fsr |= 2; else if (n > 0) e_fsr |= 1;
    chk("R1 count", cnt, n);
    chk("R4/R5 fsr", fsr, e_fsr);
    chk("R6 ready", rdy, (n < lim_of(lsel)) ? 1 : 0);
    chk("R8 rdata", rdata, (n > 0) ? q[0] : 0);
    chk("R2 overrun", ovr, m_ovr);
  endtask

  task automatic step(input bit p, input byte unsigned d, input bit r,
                      input bit f = 0, input bit c = 0);
    bit popped, drop;
    push = p; din = d; pop = r; flush = f; ovr_clr = c;
    @(posedge clk);
    if (f) q.delete();
    else begin
      popped = r && q.size() > 0;
      drop = p && q.size() == 16 && !popped;
      if (popped) void'(q.pop_front());
      if (p && !drop) q.push_back(d);
      if (drop) m_ovr = 1; else if (c) m_ovr = 0;
    end
    @(negedge clk);
    push = 0; pop = 0; flush = 0; ovr_clr = 0;
    check_all();
  endtask

  task automatic t_reset();
    chk("R7 fsr reset", fsr, 16'h0060);
    chk("R7 count reset", cnt, 0);
    chk("R7 overrun reset", ovr, 0);
  endtask

  task automatic t_triggers();
    for (int s = 0; s < 4; s++) begin
      tsel = 2'(s);
      for (int i = 0; i < 15; i++) step(1, byte'(8'h10 + i), 0);
      for (int i = 0; i < 15; i++) step(0, 0, 1);
      chk("R3 trigger empty", fsr[1:0], 0);
    end
    tsel = 0;
  endtask

  task automatic t_limits();
    for (int s = 0; s < 8; s++) begin
      lsel = 3'(s);
      check_all();
      for (int i = 0; i < 16; i++) step(1, byte'(i * 3), 0);
      chk("R6 pushes not gated", cnt, 16);
      step(0, 0, 0, 1);
    end
    lsel = 0;
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) step(1, byte'(8'hA0 + i), 0);
    for (int i = 0; i < 5; i++) begin
      chk("R8 order", rdata, 8'hA0 + i);
      step(0, 0, 1);
    end
    step(0, 0, 1);
    chk("R8 pop empty ignored", cnt, 0);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 16; i++) step(1, byte'(8'h40 + i), 0);
    step(1, 8'hEE, 0);
    chk("R2 overrun set", ovr, 1);
    chk("R2 dropped byte count", cnt, 16);
    step(1, 8'hEF, 0, 0, 1);
    chk("R2 discard wins over clear", ovr, 1);
    step(0, 0, 0, 0, 1);
    chk("R2 clear", ovr, 0);
    step(1, 8'h77, 1);
    chk("R9 full push+pop count", cnt, 16);
    chk("R9 full push+pop head", rdata, 8'h41);
    for (int i = 0; i < 15; i++) step(0, 0, 1);
    chk("R9 last byte kept", rdata, 8'h77);
    step(0, 0, 1);
  endtask

  task automatic t_simul();
    step(1, 8'h01, 0);
    step(1, 8'h02, 0);
    step(1, 8'h03, 1);
    chk("R9 count held", cnt, 2);
    chk("R9 head advanced", rdata, 8'h02);
    step(0, 0, 1);
    step(0, 0, 1);
  endtask

  task automatic t_flush();
    tsel = 1;
    for (int i = 0; i < 6; i++) step(1, byte'(i), 0);
    step(1, 8'h99, 0, 1);
    chk("R10 flush count", cnt, 0);
    chk("R10 flush flags", fsr[1:0], 0);
    chk("R10 flush no overrun", ovr, 0);
    chk("R10 flush rdata", rdata, 0);
    tsel = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    check_all();
    t_triggers();
    t_limits();
    t_order();
    t_overrun();
    t_simul();
    t_flush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule